// File: doc/BRIEF.md
# Hold-Request Conversion Scheduler

This block shares one converter among three sampling channels. Each channel has a hold line. A rising edge on a hold line marks a sample that needs converting. The block takes these edges on the falling clock edge and keeps one pending bit per channel. On a rising edge it launches the best pending channel with a one-cycle start strobe and the channel index. A conversion takes a fixed number of cycles, counted inside the block. When that count ends, a done pulse appears, tagged with the channel that finished.

Requests that arrive while the converter is working are held until it is free. The next one is launched in the same cycle as the done pulse, so the converter never sits idle between queued jobs. When more than one channel is waiting, the lowest channel index wins. A second request from a channel that is already waiting folds into its one pending bit. A synchronous reset drops the running job and every waiting one.

Top module: `hold_req_sched`

## Requirements
- R1: While reset is high, and in every cycle after it is released until a new request arrives, `start_o`, `busy_o` and `done_o` are 0. A conversion that was running and any waiting requests are discarded, so none of them later produces a start or done.
- R2: With the converter idle, a hold line that rises is taken at the next falling clock edge. `start_o` is then 1 in the cycle after the following rising edge, with `sel_o` set to that channel.
- R3: `done_o` is a one-cycle pulse exactly CONV_CYCLES (default 14) cycles after the matching `start_o`, and `done_ch_o` carries that conversion's channel.
- R4: If a request is waiting when a conversion finishes, the next conversion's `start_o` comes in the same cycle as that `done_o`.
- R5: Channel encoding is A=0, B=1, C=2 on `hold_i` bits and on `sel_o`/`done_ch_o`. Among waiting requests the lowest index is served first: if C and A wait together, A runs before C.
- R6: A repeat request from a channel that is already waiting does not add a second conversion for that channel.
- R7: `busy_o` is 1 from the cycle of a start strobe until the done pulse of the last waiting conversion. It is 0 in that done cycle and in every idle cycle.
- R8: A hold line held high counts as a single request, and `start_o` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; hold lines are sampled on its falling edge, everything else on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | NUM_CH | Hold lines, bit 0 = A, bit 1 = B, bit 2 = C; a rising edge is a request |
| start_o | output | 1 | One-cycle strobe that starts a conversion |
| sel_o | output | SEL_W | Channel being converted |
| busy_o | output | 1 | High while conversions are running or chained |
| done_o | output | 1 | One-cycle completion pulse |
| done_ch_o | output | SEL_W | Channel that just completed |

## Verification
A wrong pending bit shows up at the ports in two ways. A bit that was lost leaves a done pulse missing at the end of the chain. A bit that was merged wrongly or never cleared gives an extra done pulse, one conversion length later. The scoreboard checks every done pulse against the expected channel order. A stale counter or a stale launch condition moves `done_o` off its exact cycle, and the bench sees that at the first pulse. A bad busy flag shows in the done cycle, where busy must either stay high with a new start or drop low.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  localparam int CHAN_W = 2;
  typedef enum logic [CHAN_W-1:0] {
    CH_A = 2'd0,
    CH_B = 2'd1,
    CH_C = 2'd2
  } chan_e;
endpackage

// File: rtl/hrs_hold_capture.sv
// Falling-edge sampling of the hold lines with rising-edge detection.
module hrs_hold_capture #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hold_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] cap_q, prev_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      prev_q <= '0;
    end else begin
      cap_q  <= hold_i;
      prev_q <= cap_q;
    end
  end

  // A request stays valid from one falling edge to the next, so it is seen by exactly one rising edge.
  assign req_o = cap_q & ~prev_q;
endmodule

// File: rtl/hrs_prio_pick.sv
// Fixed priority: the lowest index wins.
module hrs_prio_pick #(
  parameter int N = 3,
  parameter int W = 2
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/hrs_conv_timer.sv
// Counts the length of one conversion. finish_o is high in the last cycle.
module hrs_conv_timer #(
  parameter int CYCLES = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic finish_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) cnt_q <= '0;
    else if (run_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign finish_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/hold_req_sched.sv
module hold_req_sched #(
  parameter int NUM_CH      = 3,
  parameter int CONV_CYCLES = 14,
  localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hold_i,
  output logic              start_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [SEL_W-1:0]  done_ch_o
);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  logic [NUM_CH-1:0] req, pending_q, avail, grant_mask;
  logic              pick_valid, finish, launch, busy_q;
  logic [SEL_W-1:0]  pick_idx;

  hrs_hold_capture #(.N(NUM_CH)) u_cap (
    .clk(clk), .rst(rst), .hold_i(hold_i), .req_o(req)
  );

  assign avail = pending_q | req;

  hrs_prio_pick #(.N(NUM_CH), .W(SEL_W)) u_pick (
    .req_i(avail), .valid_o(pick_valid), .idx_o(pick_idx)
  );

  hrs_conv_timer #(.CYCLES(CONV_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .load_i(launch), .run_i(busy_q), .finish_o(finish)
  );

  // A new job launches when the converter is idle or finishing in this cycle.
  assign launch     = pick_valid && (!busy_q || finish);
  assign grant_mask = launch ? (ONE << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      busy_q    <= 1'b0;
      start_o   <= 1'b0;
      sel_o     <= '0;
      done_o    <= 1'b0;
      done_ch_o <= '0;
    end else begin
      pending_q <= avail & ~grant_mask;
      start_o   <= launch;
      done_o    <= finish;
      if (finish) done_ch_o <= sel_o;
      if (launch) begin
        sel_o  <= pick_idx;
        busy_q <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/hrs_sched_chk.sv
module hrs_sched_chk #(
  parameter int CONV_CYCLES = 14,
  parameter int SEL_W       = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start_o,
  input logic [SEL_W-1:0] sel_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [SEL_W-1:0] done_ch_o
);
  int               since_start;
  logic [SEL_W-1:0] sel_at_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_start  <= 0;
      sel_at_start <= '0;
    end else begin
      if (start_o) begin
        since_start  <= 1;
        sel_at_start <= sel_o;
      end else if (since_start < CONV_CYCLES + 2) begin
        since_start <= since_start + 1;
      end
    end
  end

  // R3: the done pulse lands exactly one conversion length after the start strobe
  p_done_timing_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> since_start == CONV_CYCLES);

  // R3: the done pulse carries the channel that was started
  p_done_tag_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> done_ch_o == sel_at_start);

  // R8: the start strobe never lasts two cycles
  p_start_single_r8: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R7: busy is high whenever a start strobe is out
  p_busy_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o);

  // R7: busy drops only together with a done pulse
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy_o)) |-> done_o);

  // R1: no completion can appear while idle
  p_no_idle_done_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy_o)) |-> !done_o);
endmodule

bind hold_req_sched hrs_sched_chk #(
  .CONV_CYCLES(CONV_CYCLES),
  .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .start_o(start_o), .sel_o(sel_o),
  .busy_o(busy_o), .done_o(done_o), .done_ch_o(done_ch_o)
);

// File: tb/hold_req_sched_test.sv
module hold_req_sched_test;
  import hrs_pkg::*;

  localparam int CONV = 14;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] hold;
  logic       start_o, busy_o, done_o;
  logic [1:0] sel_o, done_ch_o;

  always #2 clk = ~clk;

  hold_req_sched #(.NUM_CH(3), .CONV_CYCLES(CONV)) uut (
    .clk(clk), .rst(rst), .hold_i(hold), .start_o(start_o), .sel_o(sel_o),
    .busy_o(busy_o), .done_o(done_o), .done_ch_o(done_ch_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc = 0;
  int start_cyc = 0;
  int exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each done pulse
  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst) begin
      if (done_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected done", int'(done_ch_o), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(done_ch_o) == e, "R5 done order", int'(done_ch_o), e);
          check(cyc - start_cyc == CONV, "R3 duration", cyc - start_cyc, CONV);
          if (exp_q.size() > 0)
            check(start_o && busy_o, "R4 next start with done", int'(start_o), 1);
          else
            check(!busy_o, "R7 busy low at last done", int'(busy_o), 0);
        end
      end
      if (start_o) start_cyc = cyc;
    end
  end

  task automatic pulse(input logic [2:0] m);
    @(posedge clk); #1 hold = m;
    @(posedge clk); #1 hold = 3'b000;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      if (exp_q.size() == 0 && !busy_o) break;
    end
    check(exp_q.size() == 0, "R4 all queued work done", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    rst  = 1'b1;
    hold = 3'b000;
    repeat (3) @(posedge clk);
    #1;
    check(!start_o && !busy_o && !done_o, "R1 reset state",
          int'({start_o, busy_o, done_o}), 0);
    rst = 1'b0;
    repeat (3) @(posedge clk);
    #1 check(!busy_o && !start_o, "R1 idle after reset", int'(busy_o), 0);

    // S1: single request from idle
    exp_q.push_back(int'(CH_A));
    pulse(3'b001);
    check(start_o == 1'b1, "R2 start on next rising edge", int'(start_o), 1);
    check(sel_o == CH_A, "R2 select A", int'(sel_o), int'(CH_A));
    check(busy_o == 1'b1, "R7 busy at start", int'(busy_o), 1);
    @(posedge clk); #1;
    check(start_o == 1'b0, "R8 start one cycle", int'(start_o), 0);
    repeat (6) @(posedge clk);
    #1 check(busy_o == 1'b1, "R7 busy mid conversion", int'(busy_o), 1);
    wait_idle();

    // S2: B running, then C and A requested together -> B, A, C
    exp_q.push_back(int'(CH_B));
    exp_q.push_back(int'(CH_A));
    exp_q.push_back(int'(CH_C));
    pulse(3'b010);
    check(sel_o == CH_B, "R2 select B", int'(sel_o), int'(CH_B));
    repeat (2) @(posedge clk);
    pulse(3'b101);
    wait_idle();

    // S3: all three together from idle -> A, B, C
    exp_q.push_back(int'(CH_A));
    exp_q.push_back(int'(CH_B));
    exp_q.push_back(int'(CH_C));
    pulse(3'b111);
    check(sel_o == CH_A, "R5 A first", int'(sel_o), int'(CH_A));
    wait_idle();

    // S4: repeated B requests while C runs merge into one
    exp_q.push_back(int'(CH_C));
    exp_q.push_back(int'(CH_B));
    pulse(3'b100);
    pulse(3'b010);
    repeat (2) @(posedge clk);
    pulse(3'b010);
    wait_idle();
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1;
      if (i == 29) check(!busy_o, "R6 no second B conversion", int'(busy_o), 0);
    end

    // S5: a hold line left high gives one conversion only
    exp_q.push_back(int'(CH_A));
    @(posedge clk); #1 hold = 3'b001;
    repeat (40) @(posedge clk);
    #1 check(!busy_o, "R8 level hold single request", int'(busy_o), 0);
    hold = 3'b000;
    check(exp_q.size() == 0, "R8 one conversion done", exp_q.size(), 0);

    // S6: reset in the middle of a conversion with work waiting
    pulse(3'b010);
    pulse(3'b100);
    repeat (4) @(posedge clk);
    #1 rst = 1'b1;
    exp_q.delete();
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    check(!busy_o && !start_o, "R1 reset cancels", int'(busy_o), 0);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (busy_o || start_o) begin
        check(1'b0, "R1 cancelled work restarted", int'(busy_o), 0);
        break;
      end
    end
    check(!busy_o, "R1 stays idle after reset", int'(busy_o), 0);

    finish_run();
  end
endmodule